// File: doc/BRIEF.md
# TDM Connection Memory Output Controller

This block drives one output port of a time-slot switch. A channel-slot counter presents one output slot per clock. The block reads the 16-bit connection word for that slot and decides what the slot carries. There are three outcomes. The slot can carry a byte switched from a chosen stream and channel on either of two input ports. It can carry a fixed message byte stored in the word itself. Or it can carry nothing, with the output-enable dropped so that the serializer holds the line at high impedance.

The connection memory and the switched-data memory sit outside the block, and both are read synchronously. The block issues the connection-memory address in the slot's own cycle. One cycle later it decodes the returned word and issues the data-memory address and port select. Message bytes are delayed by one stage so that they line up with switched data. The per-slot result is registered three cycles after the slot was presented.

The same code serves the local and the backplane output port. A parameter flips the meaning of the source-select bit, because that bit has opposite polarity on the two ports.

Top module: `tdm_cm_outctl`

## Requirements
- R1: While reset is held and right after it, `ch_vld_o` and `ch_oe_o` are 0 and `ch_data_o` equals the idle byte (default 8'hFF).
- R2: In the cycle a slot is presented, `cm_raddr_o` equals `slot_i` ({stream[3:0], channel[8:0]}) and `cm_rd_o` equals `slot_vld_i`. The connection word is expected on `cm_rdata_i` one cycle later.
- R3: A connection word with bit 14 = 0 and bit 13 = 1 makes the block drive `dm_rd_o` = 1 and `dm_raddr_o` = word[12:0] one cycle after the slot. In that field, bits 12:9 are the source stream and bits 8:0 are the source channel.
- R4: `dm_port_o` is 1 for the local port and 0 for the backplane port. With `LOCAL_SIDE` = 1, word bit 15 = 1 selects local. With `LOCAL_SIDE` = 0, word bit 15 = 0 selects local.
- R5: For an enabled connection word, three cycles after the slot `ch_vld_o` = 1, `ch_oe_o` = 1, and `ch_data_o` equals the `dm_rdata_i` value that was returned two cycles after the slot.
- R6: A word with bit 14 = 1 and bit 13 = 1 is a message. Three cycles after the slot it outputs word[7:0] with `ch_oe_o` = 1, regardless of bits 12:8, and `dm_rd_o` stays 0 for that slot.
- R7: A word with bit 13 = 0, in either mode, gives `ch_oe_o` = 0 and `ch_data_o` = idle byte three cycles after the slot, and `dm_rd_o` = 0 for that slot.
- R8: A slot presented with `slot_vld_i` = 0 yields `ch_vld_o` = 0, `ch_oe_o` = 0 and `dm_rd_o` = 0 in the corresponding later cycles.
- R9: The block accepts a new slot every clock. Consecutive slots of different kinds produce independent results in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld_i | input | 1 | Slot counter output is valid this cycle |
| slot_i | input | 13 | Output slot, {stream, channel} |
| cm_rd_o | output | 1 | Connection memory read strobe |
| cm_raddr_o | output | 13 | Connection memory read address |
| cm_rdata_i | input | 16 | Connection word, one cycle after the address |
| dm_rd_o | output | 1 | Switched-data memory read strobe |
| dm_port_o | output | 1 | Source port, 1 = local, 0 = backplane |
| dm_raddr_o | output | 13 | Source {stream, channel} |
| dm_rdata_i | input | 8 | Switched byte, one cycle after the address |
| ch_vld_o | output | 1 | Output slot result is valid |
| ch_oe_o | output | 1 | Drive the channel (0 = high impedance) |
| ch_data_o | output | 8 | Byte for the output channel |

## Verification
The bench builds two copies at the default geometry of 16 streams by 512 channels with 16-bit words, one with `LOCAL_SIDE` = 1 and one with `LOCAL_SIDE` = 0. Both copies receive identical slots and connection words. This exercises both polarities of the source-select bit on the same word, so a swapped port shows up as a data mismatch. At this geometry the data field fills all 13 low bits. Directed words reach the extreme source addresses 0 and 8191, as well as a message word whose ignored bits are all set.

// File: rtl/tdm_cm_pkg.sv
package tdm_cm_pkg;

   // Outcome of one output slot after decoding its connection word
   typedef enum logic [1:0] {
      KIND_IDLE   = 2'd0,
      KIND_SWITCH = 2'd1,
      KIND_MSG    = 2'd2
   } slot_kind_e;

   // Encoding of the data-memory port select
   typedef enum logic {
      SRC_BACKPLANE = 1'b0,
      SRC_LOCAL     = 1'b1
   } src_port_e;

endpackage

// File: rtl/cm_word_decode.sv
module cm_word_decode
   import tdm_cm_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int ADDR_W     = 13,
   parameter int BYTE_W     = 8,
   parameter bit LOCAL_SIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [WORD_W-1:0] word_i,
   output slot_kind_e        kind_o,
   output logic              port_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BYTE_W-1:0] msg_o,
   output logic              dm_rd_o
);

   localparam int SRC_BIT  = WORD_W - 1;
   localparam int MODE_BIT = WORD_W - 2;
   localparam int EN_BIT   = WORD_W - 3;

   initial begin : p_param_chk
      assert (ADDR_W == WORD_W - 3)
         else $error("cm_word_decode: address field must fill the word below the control bits");
      assert (BYTE_W <= ADDR_W)
         else $error("cm_word_decode: message byte wider than the address field");
   end

   // Source-select polarity differs between the two output ports
   generate
      if (LOCAL_SIDE) begin : g_local_side
         assign port_o = word_i[SRC_BIT];
      end else begin : g_backplane_side
         assign port_o = ~word_i[SRC_BIT];
      end
   endgenerate

   assign addr_o = word_i[ADDR_W-1:0];
   assign msg_o  = word_i[BYTE_W-1:0];

   always_comb begin
      kind_o = KIND_IDLE;
      if (vld_i && word_i[EN_BIT]) begin
         kind_o = word_i[MODE_BIT] ? KIND_MSG : KIND_SWITCH;
      end
   end

   assign dm_rd_o = (kind_o == KIND_SWITCH);

   AST_DM_RD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      dm_rd_o |-> vld_i) else $error("data read without a valid slot"); // R8

   AST_DM_RD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      dm_rd_o |-> (word_i[EN_BIT] && !word_i[MODE_BIT])) else $error("data read for a disabled or message word"); // R7

endmodule

// File: rtl/cm_align_stage.sv
module cm_align_stage
   import tdm_cm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  slot_kind_e        kind_i,
   input  logic [BYTE_W-1:0] msg_i,
   output logic              vld_o,
   output slot_kind_e        kind_o,
   output logic [BYTE_W-1:0] msg_o
);

   // Holds decode results for the cycle the data memory needs to answer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         kind_o <= KIND_IDLE;
         msg_o  <= '0;
      end else begin
         vld_o  <= vld_i;
         kind_o <= kind_i;
         if (kind_i == KIND_MSG) begin
            msg_o <= msg_i;
         end
      end
   end

endmodule

// File: rtl/cm_out_select.sv
module cm_out_select
   import tdm_cm_pkg::*;
#(
   parameter int               BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] IDLE_BYTE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  slot_kind_e        kind_i,
   input  logic [BYTE_W-1:0] msg_i,
   input  logic [BYTE_W-1:0] dm_rdata_i,
   output logic              ch_vld_o,
   output logic              ch_oe_o,
   output logic [BYTE_W-1:0] ch_data_o
);

   logic [BYTE_W-1:0] data_nxt;
   logic              oe_nxt;

   always_comb begin
      unique case (kind_i)
         KIND_SWITCH: begin
            data_nxt = dm_rdata_i;
            oe_nxt   = 1'b1;
         end
         KIND_MSG: begin
            data_nxt = msg_i;
            oe_nxt   = 1'b1;
         end
         default: begin
            data_nxt = IDLE_BYTE;
            oe_nxt   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_vld_o  <= 1'b0;
         ch_oe_o   <= 1'b0;
         ch_data_o <= IDLE_BYTE;
      end else begin
         ch_vld_o  <= vld_i;
         ch_oe_o   <= oe_nxt;
         ch_data_o <= data_nxt;
      end
   end

   AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_oe_o |-> (ch_data_o == IDLE_BYTE)) else $error("undriven slot carries data"); // R7

   AST_OE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      ch_oe_o |-> ch_vld_o) else $error("enable on an invalid slot"); // R8

   AST_SWITCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_oe_o && $past(kind_i == KIND_SWITCH)) |-> (ch_data_o == $past(dm_rdata_i))) else $error("switched byte lost"); // R5

   AST_MSG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_oe_o && $past(kind_i == KIND_MSG)) |-> (ch_data_o == $past(msg_i))) else $error("message byte lost"); // R6

endmodule

// File: rtl/tdm_cm_outctl.sv
module tdm_cm_outctl
   import tdm_cm_pkg::*;
#(
   parameter int                STREAMS    = 16,
   parameter int                CHANNELS   = 512,
   parameter int                WORD_W     = 16,
   parameter int                BYTE_W     = 8,
   parameter bit                LOCAL_SIDE = 1'b1,
   parameter logic [BYTE_W-1:0] IDLE_BYTE  = '1,
   localparam int               STRM_W     = $clog2(STREAMS),
   localparam int               CHAN_W     = $clog2(CHANNELS),
   localparam int               ADDR_W     = STRM_W + CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_vld_i,
   input  logic [ADDR_W-1:0] slot_i,
   output logic              cm_rd_o,
   output logic [ADDR_W-1:0] cm_raddr_o,
   input  logic [WORD_W-1:0] cm_rdata_i,
   output logic              dm_rd_o,
   output logic              dm_port_o,
   output logic [ADDR_W-1:0] dm_raddr_o,
   input  logic [BYTE_W-1:0] dm_rdata_i,
   output logic              ch_vld_o,
   output logic              ch_oe_o,
   output logic [BYTE_W-1:0] ch_data_o
);

   initial begin : p_geom_chk
      assert (STREAMS == (1 << STRM_W))
         else $error("tdm_cm_outctl: STREAMS must be a power of two");
      assert (CHANNELS == (1 << CHAN_W))
         else $error("tdm_cm_outctl: CHANNELS must be a power of two");
      assert (WORD_W == ADDR_W + 3)
         else $error("tdm_cm_outctl: word must hold three control bits and the source address");
   end

   // Stage 0: slot address goes straight to the connection memory
   assign cm_rd_o    = slot_vld_i;
   assign cm_raddr_o = slot_i;

   // Stage 1: word returns; track validity alongside
   logic s1_vld;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
      end else begin
         s1_vld <= slot_vld_i;
      end
   end

   slot_kind_e        s1_kind;
   logic [BYTE_W-1:0] s1_msg;

   cm_word_decode #(
      .WORD_W     (WORD_W),
      .ADDR_W     (ADDR_W),
      .BYTE_W     (BYTE_W),
      .LOCAL_SIDE (LOCAL_SIDE)
   ) i_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (s1_vld),
      .word_i  (cm_rdata_i),
      .kind_o  (s1_kind),
      .port_o  (dm_port_o),
      .addr_o  (dm_raddr_o),
      .msg_o   (s1_msg),
      .dm_rd_o (dm_rd_o)
   );

   // Stage 2: wait for the data memory; message byte travels alongside
   logic              s2_vld;
   slot_kind_e        s2_kind;
   logic [BYTE_W-1:0] s2_msg;

   cm_align_stage #(
      .BYTE_W (BYTE_W)
   ) i_align (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s1_vld),
      .kind_i (s1_kind),
      .msg_i  (s1_msg),
      .vld_o  (s2_vld),
      .kind_o (s2_kind),
      .msg_o  (s2_msg)
   );

   // Stage 3: registered channel result
   cm_out_select #(
      .BYTE_W    (BYTE_W),
      .IDLE_BYTE (IDLE_BYTE)
   ) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_i      (s2_vld),
      .kind_i     (s2_kind),
      .msg_i      (s2_msg),
      .dm_rdata_i (dm_rdata_i),
      .ch_vld_o   (ch_vld_o),
      .ch_oe_o    (ch_oe_o),
      .ch_data_o  (ch_data_o)
   );

   AST_MSG_NO_DM: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_kind == KIND_MSG) |-> !$past(dm_rd_o)) else $error("message slot read data memory"); // R6

   AST_SWITCH_HAD_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_kind == KIND_SWITCH) |-> $past(dm_rd_o)) else $error("switched slot skipped its data read"); // R3

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_vld_o |-> $past(s2_vld)) else $error("output valid without a staged slot"); // R9

endmodule

// File: tb/test_tdm_cm_outctl.sv
`timescale 1ns/1ps
module test_tdm_cm_outctl;

   localparam int ADDR_W = 13;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;
   localparam logic [7:0] IDLE = 8'hFF;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n;
   logic              slot_vld;
   logic [ADDR_W-1:0] slot;
   logic [WORD_W-1:0] cm_rdata;
   logic [BYTE_W-1:0] dm_rdata_a, dm_rdata_b;

   logic              cm_rd_a, cm_rd_b, dm_rd_a, dm_rd_b, port_a, port_b;
   logic [ADDR_W-1:0] cm_addr_a, cm_addr_b, dm_addr_a, dm_addr_b;
   logic              vld_a, vld_b, oe_a, oe_b;
   logic [BYTE_W-1:0] data_a, data_b;

   tdm_cm_outctl #(.LOCAL_SIDE(1'b1)) i_tdm_cm_outctl (
      .clk(clk), .rst_n(rst_n), .slot_vld_i(slot_vld), .slot_i(slot),
      .cm_rd_o(cm_rd_a), .cm_raddr_o(cm_addr_a), .cm_rdata_i(cm_rdata),
      .dm_rd_o(dm_rd_a), .dm_port_o(port_a), .dm_raddr_o(dm_addr_a),
      .dm_rdata_i(dm_rdata_a), .ch_vld_o(vld_a), .ch_oe_o(oe_a), .ch_data_o(data_a));

   tdm_cm_outctl #(.LOCAL_SIDE(1'b0)) i_tdm_cm_outctl_bp (
      .clk(clk), .rst_n(rst_n), .slot_vld_i(slot_vld), .slot_i(slot),
      .cm_rd_o(cm_rd_b), .cm_raddr_o(cm_addr_b), .cm_rdata_i(cm_rdata),
      .dm_rd_o(dm_rd_b), .dm_port_o(port_b), .dm_raddr_o(dm_addr_b),
      .dm_rdata_i(dm_rdata_b), .ch_vld_o(vld_b), .ch_oe_o(oe_b), .ch_data_o(data_b));

   // Small connection table indexed by the low slot bits
   logic [WORD_W-1:0] cmtab [64];

   function automatic logic [7:0] dm_byte(input logic port, input logic [ADDR_W-1:0] a);
      return a[7:0] ^ {3'b0, a[12:8]} ^ (port ? 8'h5A : 8'hC3);
   endfunction

   always @(posedge clk) begin
      cm_rdata   <= cmtab[cm_addr_a[5:0]];
      dm_rdata_a <= dm_byte(port_a, dm_addr_a);
      dm_rdata_b <= dm_byte(port_b, dm_addr_b);
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expectation ring, indexed by drive cycle modulo 4
   logic        e_vld [4];
   logic        e_oe  [4];
   logic [7:0]  e_da  [4];
   logic [7:0]  e_db  [4];
   logic        e_rd  [4];
   logic [12:0] e_adr [4];
   logic        e_pa  [4];
   logic        e_msg [4];

   task automatic predict(input int idx, input logic v, input logic [ADDR_W-1:0] s);
      logic [WORD_W-1:0] w;
      logic en, msg;
      w   = cmtab[s[5:0]];
      en  = v & w[13];
      msg = w[14];
      e_vld[idx] = v;
      e_oe[idx]  = en;
      e_rd[idx]  = en & ~msg;
      e_adr[idx] = w[12:0];
      e_pa[idx]  = w[15];
      e_msg[idx] = msg;
      if (!en) begin
         e_da[idx] = IDLE; e_db[idx] = IDLE;
      end else if (msg) begin
         e_da[idx] = w[7:0]; e_db[idx] = w[7:0];
      end else begin
         e_da[idx] = dm_byte(w[15], w[12:0]);
         e_db[idx] = dm_byte(~w[15], w[12:0]);
      end
   endtask

   int cyc = 0;

   task automatic step(input logic v, input logic [ADDR_W-1:0] s);
      int p1, p3;
      // Checks for earlier slots, sampled at the falling edge
      if (cyc >= 1) begin
         p1 = (cyc - 1) % 4;
         chk("R3/R6/R7/R8 dm_rd", {31'b0, dm_rd_a}, {31'b0, e_rd[p1]});
         chk("R8 dm_rd bp copy", {31'b0, dm_rd_b}, {31'b0, e_rd[p1]});
         if (e_rd[p1]) begin
            chk("R3 dm_raddr", {19'b0, dm_addr_a}, {19'b0, e_adr[p1]});
            chk("R4 port local side", {31'b0, port_a}, {31'b0, e_pa[p1]});
            chk("R4 port backplane side", {31'b0, port_b}, {31'b0, ~e_pa[p1]});
         end
      end
      if (cyc >= 3) begin
         p3 = (cyc - 3) % 4;
         chk("R8/R9 ch_vld", {31'b0, vld_a}, {31'b0, e_vld[p3]});
         chk("R5/R6/R7 ch_oe", {31'b0, oe_a}, {31'b0, e_oe[p3]});
         chk(e_msg[p3] ? "R6 data local side" : "R5/R7 data local side", {24'b0, data_a}, {24'b0, e_da[p3]});
         chk(e_msg[p3] ? "R6 data bp side" : "R4/R5/R7 data bp side", {24'b0, data_b}, {24'b0, e_db[p3]});
         chk("R9 ch_oe bp copy", {31'b0, oe_b}, {31'b0, e_oe[p3]});
      end
      slot_vld = v;
      slot     = s;
      predict(cyc % 4, v, s);
      #1;
      chk("R2 cm_raddr", {19'b0, cm_addr_a}, {19'b0, s});
      chk("R2 cm_rd", {31'b0, cm_rd_a}, {31'b0, v});
      cyc++;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n    = 1'b0;
      slot_vld = 1'b0;
      slot     = '0;
      cmtab[0] = 16'hA7A5; // switch, bit15=1, stream 3 ch 0x1A5
      cmtab[1] = 16'h7F3C; // message, ignored bits all set
      cmtab[2] = 16'h40AB; // message, not enabled
      cmtab[3] = 16'h8123; // switch, not enabled
      cmtab[4] = 16'h3FFF; // switch, bit15=0, highest source address
      cmtab[5] = 16'hA000; // switch, bit15=1, lowest source address
      cmtab[6] = 16'h6000; // message byte 00
      cmtab[7] = 16'hE0FF; // message with bit15 set
      for (int i = 8; i < 64; i++) cmtab[i] = 16'($urandom);

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset ch_vld", {31'b0, vld_a}, 32'd0);
      chk("R1 reset ch_oe", {31'b0, oe_a}, 32'd0);
      chk("R1 reset ch_data", {24'b0, data_a}, {24'b0, IDLE});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset ch_oe", {31'b0, oe_b}, 32'd0);
      chk("R1 after reset ch_data", {24'b0, data_b}, {24'b0, IDLE});

      // Directed: every corner word back to back, then an invalid gap
      for (int i = 0; i < 8; i++) step(1'b1, 13'(i) | 13'h1C0);
      step(1'b0, 13'h0001);
      step(1'b0, 13'h0000);
      step(1'b1, 13'h1FC1);
      step(1'b0, 13'h0004);

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 8) != 0, 13'($urandom));
      end
      for (int n = 0; n < 4; n++) step(1'b0, '0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule